// File: doc/BRIEF.md
# DMA Request and Interrupt Router

This block sits between a two-channel serial controller and a host bus. It holds one host-writable configuration byte. That byte steers the controller's request pins onto a transmit DMA request and a receive DMA request. It also picks one of three interrupt sources and drives it onto a bus interrupt line. The line can either be shared with other cards or owned outright.

The transmit request can come from either of two channel A pins. The receive request can come from a channel A pin or a channel B pin. The channel A wait/request pin appears in both choices. If both DMA paths are enabled and both select that pin, the router raises a conflict flag and holds both requests low. In sharing mode the interrupt pin is driven only while the chosen source is active and is released otherwise. In dedicated mode the pin is always driven. The terminal-count source is honoured only in sharing mode.

Top module: `dma_irq_router`

## Requirements
- R1: A synchronous active-high reset clears the configuration byte, so readback is 0x00, both DMA requests are low and no interrupt source is selected.
- R2: A write stores data bits 5:0 on the next rising clock edge. Readback returns those six bits, with bits 7:6 always reading 0 whatever was written to them.
- R3: Bit 2 enables the transmit request. When it is set, the transmit request follows the channel A DTR/request pin if bit 0 is 1, or the channel A wait/request pin if bit 0 is 0. When bit 2 is clear, the transmit request is low.
- R4: Bit 3 enables the receive request. When it is set, the receive request follows the channel B wait/request pin if bit 1 is 1, or the channel A wait/request pin if bit 1 is 0. When bit 3 is clear, the receive request is low.
- R5: When bits 3 and 2 are both 1 and bits 1 and 0 are both 0, the conflict flag is 1 and both DMA requests are held low regardless of the pins. In every other setting the conflict flag is 0.
- R6: Bits 5:4 choose the interrupt source: 00 none, 01 terminal count, 10 controller interrupt, 11 test-mode line. The interrupt output is high exactly when the chosen source is high.
- R7: With bits 5:4 = 01 and the sharing strap low, the interrupt output stays low whatever the terminal-count input does.
- R8: With the sharing strap high, the interrupt output enable equals the interrupt output, so the line floats when idle. With the strap low, the enable is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration readback |
| chAWaitReq | input | 1 | Channel A wait/request pin |
| chADtrReq | input | 1 | Channel A DTR/request pin |
| chBWaitReq | input | 1 | Channel B wait/request pin |
| dmaTermCount | input | 1 | DMA terminal-count indication |
| ctrlIrq | input | 1 | Serial controller interrupt |
| testMode | input | 1 | Test-mode line |
| shareEn | input | 1 | Interrupt sharing strap (1 = shared) |
| txDmaReq | output | 1 | Transmit DMA request to bus |
| rxDmaReq | output | 1 | Receive DMA request to bus |
| irqOut | output | 1 | Interrupt line value |
| irqOe | output | 1 | Interrupt line output enable |
| srcConflict | output | 1 | Illegal shared-pin source setting |

## Verification
The sweep writes every one of the 64 meaningful configuration values, with the reserved bits also set on some writes. For each value it applies all eight request-pin patterns, all eight interrupt-input patterns and both strap settings. The pin patterns show which pin each path follows and expose any leak of a request through a disabled or conflicting path. The interrupt patterns, checked under both straps, separate the four source codes from one another. They also isolate the terminal-count case in dedicated mode and confirm that the line floats when idle in shared mode. A reset applied partway through, after a non-zero write, shows that the register clears.

// File: rtl/router_pkg.sv
`timescale 1ns/1ps
package router_pkg;
  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_TC   = 2'b01,
    IRQ_CTRL = 2'b10,
    IRQ_TEST = 2'b11
  } irqSel_e;

  localparam int IRQ_SRC_N = 3;

  typedef struct packed {
    irqSel_e irqSel;
    logic    rxEn;
    logic    txEn;
    logic    rxSrcB;
    logic    txSrcDtr;
  } cfgFields_t;

  localparam int FIELD_W = $bits(cfgFields_t);
  localparam int RSVD_W  = CFG_W - FIELD_W;

  typedef struct packed {
    logic                 loadCfg;
    logic                 txPass;
    logic                 rxPass;
    logic                 conflict;
    logic [IRQ_SRC_N-1:0] irqPick;
  } ctrlStrobes_t;
endpackage

// File: rtl/router_ctrl.sv
`timescale 1ns/1ps
module router_ctrl
  import router_pkg::*;
(
  input  logic         cfgWrEn,
  input  cfgFields_t   cfg,
  input  logic         shareEn,
  output ctrlStrobes_t strobes
);
  logic clash;
  logic [IRQ_SRC_N-1:0] pick;

  // Both paths enabled and both parked on the channel A wait/request pin
  assign clash = cfg.txEn && cfg.rxEn && !cfg.txSrcDtr && !cfg.rxSrcB;

  // Source k is picked by select code k+1; terminal count (k=0) needs sharing
  for (genvar k = 0; k < IRQ_SRC_N; k++) begin : gPick
    localparam logic [1:0] CODE = 2'(k + 1);
    if (k == 0) begin : gTc
      assign pick[k] = (cfg.irqSel == irqSel_e'(CODE)) && shareEn;
    end else begin : gOther
      assign pick[k] = (cfg.irqSel == irqSel_e'(CODE));
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.loadCfg  = cfgWrEn;
    strobes.conflict = clash;
    strobes.txPass   = cfg.txEn && !clash;
    strobes.rxPass   = cfg.rxEn && !clash;
    strobes.irqPick  = pick;
  end
endmodule

// File: rtl/router_datapath.sv
`timescale 1ns/1ps
module router_datapath
  import router_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [CFG_W-1:0]   cfgWrData,
  input  logic               chAWaitReq,
  input  logic               chADtrReq,
  input  logic               chBWaitReq,
  input  logic               dmaTermCount,
  input  logic               ctrlIrq,
  input  logic               testMode,
  input  logic               shareEn,
  output cfgFields_t         cfg,
  output logic [CFG_W-1:0]   cfgRdData,
  output logic               txDmaReq,
  output logic               rxDmaReq,
  output logic               irqOut,
  output logic               irqOe
);
  cfgFields_t cfgReg;
  logic txPin, rxPin, irqActive;
  logic [IRQ_SRC_N-1:0] srcVec;

  always_ff @(posedge clk) begin
    if (rst)                  cfgReg <= '0;
    else if (strobes.loadCfg) cfgReg <= cfgFields_t'(cfgWrData[FIELD_W-1:0]);
  end

  assign cfg       = cfgReg;
  assign cfgRdData = {{RSVD_W{1'b0}}, cfgReg};

  assign txPin    = cfgReg.txSrcDtr ? chADtrReq : chAWaitReq;
  assign rxPin    = cfgReg.rxSrcB   ? chBWaitReq : chAWaitReq;
  assign txDmaReq = strobes.txPass && txPin;
  assign rxDmaReq = strobes.rxPass && rxPin;

  assign srcVec    = {testMode, ctrlIrq, dmaTermCount};
  assign irqActive = |(strobes.irqPick & srcVec);
  assign irqOut    = irqActive;
  assign irqOe     = shareEn ? irqActive : 1'b1;
endmodule

// File: rtl/dma_irq_router.sv
`timescale 1ns/1ps
module dma_irq_router
  import router_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             chAWaitReq,
  input  logic             chADtrReq,
  input  logic             chBWaitReq,
  input  logic             dmaTermCount,
  input  logic             ctrlIrq,
  input  logic             testMode,
  input  logic             shareEn,
  output logic             txDmaReq,
  output logic             rxDmaReq,
  output logic             irqOut,
  output logic             irqOe,
  output logic             srcConflict
);
  ctrlStrobes_t strobes;
  cfgFields_t   cfg;

  router_ctrl uCtrl (
    .cfgWrEn (cfgWrEn),
    .cfg     (cfg),
    .shareEn (shareEn),
    .strobes (strobes)
  );

  router_datapath uData (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .cfgWrData    (cfgWrData),
    .chAWaitReq   (chAWaitReq),
    .chADtrReq    (chADtrReq),
    .chBWaitReq   (chBWaitReq),
    .dmaTermCount (dmaTermCount),
    .ctrlIrq      (ctrlIrq),
    .testMode     (testMode),
    .shareEn      (shareEn),
    .cfg          (cfg),
    .cfgRdData    (cfgRdData),
    .txDmaReq     (txDmaReq),
    .rxDmaReq     (rxDmaReq),
    .irqOut       (irqOut),
    .irqOe        (irqOe)
  );

  assign srcConflict = strobes.conflict;
endmodule

// File: rtl/router_chk.sv
`timescale 1ns/1ps
module router_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfgWrEn,
  input logic [5:0] wrLow,
  input logic [7:0] cfgRdData,
  input logic       shareEn,
  input logic       txDmaReq,
  input logic       rxDmaReq,
  input logic       irqOut,
  input logic       irqOe,
  input logic       srcConflict
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfgRdData == 8'h00));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    cfgWrEn |=> (cfgRdData[5:0] == $past(wrLow)));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfgRdData[7:6] == 2'b00);

  // R3
  tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cfgRdData[2] |-> !txDmaReq);

  // R4
  rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cfgRdData[3] |-> !rxDmaReq);

  // R5
  conflict_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    srcConflict |-> (!txDmaReq && !rxDmaReq));

  // R7
  tc_dedicated_chk: assert property (@(posedge clk) disable iff (rst)
    (!shareEn && cfgRdData[5:4] == 2'b01) |-> !irqOut);

  // R8
  shared_float_chk: assert property (@(posedge clk) disable iff (rst)
    shareEn |-> (irqOe == irqOut));

  // R8
  dedicated_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !shareEn |-> irqOe);
endmodule

bind dma_irq_router router_chk uChk (
  .clk         (clk),
  .rst         (rst),
  .cfgWrEn     (cfgWrEn),
  .wrLow       (cfgWrData[5:0]),
  .cfgRdData   (cfgRdData),
  .shareEn     (shareEn),
  .txDmaReq    (txDmaReq),
  .rxDmaReq    (rxDmaReq),
  .irqOut      (irqOut),
  .irqOe       (irqOe),
  .srcConflict (srcConflict)
);

// File: tb/tb_dma_irq_router.sv
`timescale 1ns/1ps
module tb_dma_irq_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic chAWaitReq = 0, chADtrReq = 0, chBWaitReq = 0;
  logic dmaTermCount = 0, ctrlIrq = 0, testMode = 0, shareEn = 0;
  logic txDmaReq, rxDmaReq, irqOut, irqOe, srcConflict;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dma_irq_router dut (
    .clk(clk), .rst(rst), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .chAWaitReq(chAWaitReq), .chADtrReq(chADtrReq),
    .chBWaitReq(chBWaitReq), .dmaTermCount(dmaTermCount), .ctrlIrq(ctrlIrq),
    .testMode(testMode), .shareEn(shareEn), .txDmaReq(txDmaReq),
    .rxDmaReq(rxDmaReq), .irqOut(irqOut), .irqOe(irqOe),
    .srcConflict(srcConflict)
  );

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, dedicated strap: line driven low
    cmp("R1 readback", cfgRdData, 8'h00);
    cmp("R1 txreq", {7'b0, txDmaReq}, 8'h00);
    cmp("R1 rxreq", {7'b0, rxDmaReq}, 8'h00);
    cmp("R1 irq", {6'b0, irqOut, irqOe}, 8'h01);

    for (int c = 0; c < 64; c++) begin
      logic [7:0] wv;
      wv = 8'(c) | ((c % 3 == 0) ? 8'hC0 : 8'h00);
      writeCfg(wv);
      // R2 readback of bits 5:0, reserved bits read zero
      cmp("R2 readback", cfgRdData, 8'(c));
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 8; p++) begin
          for (int q = 0; q < 8; q++) begin
            logic eTx, eRx, eCf, eIrq, eOe, txPin, rxPin;
            int sel;
            shareEn = s[0];
            chAWaitReq = p[0]; chADtrReq = p[1]; chBWaitReq = p[2];
            dmaTermCount = q[0]; ctrlIrq = q[1]; testMode = q[2];
            #1;
            eCf   = c[3] && c[2] && !c[1] && !c[0];
            txPin = c[0] ? p[1] : p[0];
            rxPin = c[1] ? p[2] : p[0];
            eTx   = c[2] && !eCf && txPin;
            eRx   = c[3] && !eCf && rxPin;
            sel   = (c >> 4) & 3;
            eIrq  = (sel == 1) ? (s[0] && q[0]) :
                    (sel == 2) ? q[1] : (sel == 3) ? q[2] : 1'b0;
            eOe   = s[0] ? eIrq : 1'b1;
            cmp("R3 txreq", {7'b0, txDmaReq}, {7'b0, eTx});
            cmp("R4 rxreq", {7'b0, rxDmaReq}, {7'b0, eRx});
            cmp("R5 conflict", {7'b0, srcConflict}, {7'b0, eCf});
            if (sel == 1 && s == 0)
              cmp("R7 tc dedicated", {7'b0, irqOut}, {7'b0, eIrq});
            else
              cmp("R6 irq", {7'b0, irqOut}, {7'b0, eIrq});
            cmp("R8 oe", {7'b0, irqOe}, {7'b0, eOe});
          end
        end
      end
    end

    // R1 reset after a live configuration
    writeCfg(8'h3D);
    shareEn = 1'b0; chAWaitReq = 1; chADtrReq = 1; chBWaitReq = 1; testMode = 1;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    cmp("R1 midrun readback", cfgRdData, 8'h00);
    cmp("R1 midrun reqs", {6'b0, txDmaReq, rxDmaReq}, 8'h00);
    cmp("R1 midrun irq", {6'b0, irqOut, irqOe}, 8'h01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule